// File: doc/BRIEF.md
# Dual-Bank Flash Sleep Controller

This block controls the low-power sleep state of two flash banks that work on their own. Software writes a 32-bit control word. Each bank has two command bits that pulse for one cycle: one sends the bank to sleep and one wakes it. Each bank also has a status bit that reads 1 while the bank is asleep. Each bank drives a sleep output toward its power switch. Each bank has a read-request / ready handshake toward the array.

A read request to a sleeping bank wakes that bank on its own. Waking starts a countdown of `WAKE_CYC` clock cycles, which is 5 µs at the configured clock. While the countdown runs the request stays pending and ready is held low. When the count ends the bank returns to normal mode and ready follows the request in the same cycle.

Each bank runs a three-state machine:
- **AWAKE**: normal mode.
- **ASLEEP**: sleep output high, status 1.
- **WAKING**: countdown running, sleep output low, status 0.

Transitions:
- **GO_SLEEP** (AWAKE→ASLEEP): on a sleep command with no wake command in the same write.
- **START_WAKE** (ASLEEP→WAKING): on a wake command or a read request.
- **WAKE_DONE** (WAKING→AWAKE): when the count ends and no sleep is pending.
- **DEFERRED_SLEEP** (WAKING→ASLEEP): when the count ends and a sleep command arrived during the countdown.

Top module: `fsleep_ctrl`

## Requirements
- R1: After reset both banks are AWAKE, both sleep outputs are 0, the read word is 0, and ready follows request at once.
- R2: Writing 1 to bit 6 (bank 0) or bit 10 (bank 1) takes an AWAKE bank to ASLEEP on that clock edge. Its sleep output then reads 1, and its status bit reads 1: bit 4 for bank 0, bit 8 for bank 1.
- R3: Writing 1 to bit 5 (bank 0) or bit 9 (bank 1) moves an ASLEEP bank to WAKING. Its status and sleep output read 0 after that edge, and ready for a held request rises exactly `WAKE_CYC` cycles after that edge.
- R4: Ready is never high for a bank that is ASLEEP or WAKING. For an AWAKE bank, ready equals request in the same cycle.
- R5: A read request seen at a clock edge while the bank is ASLEEP starts WAKING. Ready rises `WAKE_CYC` cycles after that edge, and the countdown falls by one each cycle.
- R6: When sleep and wake are both written as 1 for one bank, wake wins. An AWAKE bank stays AWAKE, and an ASLEEP bank starts WAKING.
- R7: A sleep command written during WAKING is held. At the end of the countdown the bank goes straight to ASLEEP, and ready does not rise.
- R8: Commands for one bank leave the other bank's state and outputs unchanged.
- R9: Command bits act only as one-cycle strobes. Every read-word bit except 4 and 8 reads 0, and writing bits 4, 8 or any bit other than 5, 6, 9 and 10 has no effect.
- R10: A sleep command to an ASLEEP bank, or a wake command to an AWAKE bank, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control-word write strobe |
| reg_wr_data | input | 32 | Control-word write data |
| reg_rd_data | output | 32 | Control-word read value (status bits 4 and 8) |
| bank_rd_req | input | 2 | Read request per bank |
| bank_rd_rdy | output | 2 | Read ready per bank |
| bank_sleep | output | 2 | Sleep output per bank to the power switch |

## Verification
A table of writes tests single sleep commands, repeated sleep commands, writes with no command bits, and writes with every non-command bit set. Comparing the read word and the sleep outputs against expected values separates real command decoding from bits that are only stored. Directed cases check wake latency in two ways, one triggered by a wake command and one by a read request. In each case ready must still be low in cycle `WAKE_CYC`-1 and high in cycle `WAKE_CYC`, which exposes an off-by-one in the counter. Two further cases test sleep and wake written together in each state, and a sleep written during a countdown. These separate wake priority and deferred sleep from plain last-write-wins behaviour.

// File: rtl/fsleep_pkg.sv
package fsleep_pkg;

    typedef enum logic [1:0] {
        BK_AWAKE  = 2'd0,
        BK_ASLEEP = 2'd1,
        BK_WAKING = 2'd2
    } bank_state_e;

    // Control-word layout: each bank owns a group of bits starting at
    // GRP_BASE + bank*GRP_STRIDE: status, wake, sleep at increasing offsets.
    localparam int GRP_BASE   = 4;
    localparam int GRP_STRIDE = 4;
    localparam int OFS_STATUS = 0;
    localparam int OFS_WAKE   = 1;
    localparam int OFS_SLEEP  = 2;

    function automatic int status_pos(input int bank);
        return GRP_BASE + bank * GRP_STRIDE + OFS_STATUS;
    endfunction

    function automatic int wake_pos(input int bank);
        return GRP_BASE + bank * GRP_STRIDE + OFS_WAKE;
    endfunction

    function automatic int sleep_pos(input int bank);
        return GRP_BASE + bank * GRP_STRIDE + OFS_SLEEP;
    endfunction

endpackage

// File: rtl/fsleep_cmd_dec.sv
module fsleep_cmd_dec
    import fsleep_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 2
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_BANKS-1:0] sleep_cmd,
    output logic [NUM_BANKS-1:0] wake_cmd
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
        localparam int SPOS = sleep_pos(b);
        localparam int WPOS = wake_pos(b);
        assign sleep_cmd[b] = wr_en & wr_data[SPOS];
        assign wake_cmd[b]  = wr_en & wr_data[WPOS];
    end

endmodule

// File: rtl/fsleep_wake_timer.sv
module fsleep_wake_timer #(
    parameter int WAKE_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int CW = (WAKE_CYC > 2) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAKE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run && (cnt_q == '0);

    // R5: countdown falls by one per cycle while running
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R3: a wake loads the full latency
    a_r3_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/fsleep_bank.sv
module fsleep_bank
    import fsleep_pkg::*;
#(
    parameter int WAKE_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_cmd_i,
    input  logic wake_cmd_i,
    input  logic rd_req_i,
    output logic rd_rdy_o,
    output logic sleep_o,
    output logic status_o
);

    bank_state_e state_q, state_d;
    logic        pend_q, pend_d;
    logic        tmr_load, tmr_done;
    logic        sleep_only;

    assign sleep_only = sleep_cmd_i & ~wake_cmd_i;

    fsleep_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (state_q == BK_WAKING),
        .done  (tmr_done)
    );

    // next state
    always_comb begin
        state_d  = state_q;
        pend_d   = pend_q;
        tmr_load = 1'b0;
        unique case (state_q)
            BK_AWAKE: begin
                pend_d = 1'b0;
                if (sleep_only) state_d = BK_ASLEEP;          // GO_SLEEP
            end
            BK_ASLEEP: begin
                pend_d = 1'b0;
                if (wake_cmd_i || rd_req_i) begin               // START_WAKE
                    state_d  = BK_WAKING;
                    tmr_load = 1'b1;
                end
            end
            BK_WAKING: begin
                if (wake_cmd_i)      pend_d = 1'b0;
                else if (sleep_only) pend_d = 1'b1;
                if (tmr_done) begin
                    state_d = pend_d ? BK_ASLEEP : BK_AWAKE;   // DEFERRED_SLEEP / WAKE_DONE
                    pend_d  = 1'b0;
                end
            end
            default: begin
                state_d = BK_AWAKE;
                pend_d  = 1'b0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_AWAKE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // outputs
    always_comb begin
        rd_rdy_o = 1'b0;
        sleep_o  = 1'b0;
        status_o = 1'b0;
        unique case (state_q)
            BK_AWAKE:  rd_rdy_o = rd_req_i;
            BK_ASLEEP: begin
                sleep_o  = 1'b1;
                status_o = 1'b1;
            end
            BK_WAKING: ;
            default:   ;
        endcase
    end

    // R2: sleep command alone puts an awake bank to sleep
    a_r2_go_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_AWAKE && sleep_cmd_i && !wake_cmd_i) |=> sleep_o);

    // R6: wake has priority over sleep in the same write
    a_r6_wake_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_AWAKE && wake_cmd_i) |=> !sleep_o);

    // R5: a request to a sleeping bank starts the wake
    a_r5_req_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_ASLEEP && rd_req_i) |=> (state_q == BK_WAKING));

    // R7: held sleep is applied when the count ends
    a_r7_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_WAKING && tmr_done && pend_q && !wake_cmd_i) |=> sleep_o);

    // R4: no ready in the cycle right after a wake starts
    a_r4_no_early_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_load |=> !rd_rdy_o);

endmodule

// File: rtl/fsleep_ctrl.sv
module fsleep_ctrl
    import fsleep_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 2,
    parameter int CLK_MHZ   = 250,
    parameter int WAKE_US   = 5,
    parameter int WAKE_CYC  = CLK_MHZ * WAKE_US
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [DATA_W-1:0]    reg_wr_data,
    output logic [DATA_W-1:0]    reg_rd_data,
    input  logic [NUM_BANKS-1:0] bank_rd_req,
    output logic [NUM_BANKS-1:0] bank_rd_rdy,
    output logic [NUM_BANKS-1:0] bank_sleep
);

    logic [NUM_BANKS-1:0] sleep_cmd, wake_cmd, status;

    fsleep_cmd_dec #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_dec (
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .sleep_cmd (sleep_cmd),
        .wake_cmd  (wake_cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        fsleep_bank #(.WAKE_CYC(WAKE_CYC)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .sleep_cmd_i (sleep_cmd[b]),
            .wake_cmd_i  (wake_cmd[b]),
            .rd_req_i    (bank_rd_req[b]),
            .rd_rdy_o    (bank_rd_rdy[b]),
            .sleep_o     (bank_sleep[b]),
            .status_o    (status[b])
        );

        // R4: ready never shown while the bank is powered down
        a_r4_rdy_not_sleeping: assert property (@(posedge clk) disable iff (!rst_n)
            bank_rd_rdy[b] |-> !bank_sleep[b]);

        // R2: status bit mirrors the sleep output
        a_r2_status_match: assert property (@(posedge clk) disable iff (!rst_n)
            reg_rd_data[status_pos(b)] == bank_sleep[b]);
    end

    always_comb begin
        reg_rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            reg_rd_data[status_pos(b)] = status[b];
        end
    end

endmodule

// File: tb/fsleep_ctrl_tb.sv
module fsleep_ctrl_tb;

    localparam int N = 250 * 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic [1:0]  bank_rd_req = '0;
    logic [1:0]  bank_rd_rdy;
    logic [1:0]  bank_sleep;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fsleep_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .bank_rd_req (bank_rd_req),
        .bank_rd_rdy (bank_rd_rdy),
        .bank_sleep  (bank_sleep)
    );

    // {write data, expected read word, expected sleep outputs}
    localparam logic [65:0] VEC [6] = '{
        {32'h0000_0040, 32'h0000_0010, 2'b01},  // R2 bank0 sleep
        {32'h0000_0040, 32'h0000_0010, 2'b01},  // R10 re-sleep no effect
        {32'h0000_0400, 32'h0000_0110, 2'b11},  // R2 R8 bank1 sleep
        {32'h0000_0000, 32'h0000_0110, 2'b11},  // R9 empty write
        {32'hFFFF_F99F, 32'h0000_0110, 2'b11},  // R9 non-command bits
        {32'h0000_0200, 32'h0000_0010, 2'b01}   // R3 R8 bank1 wakes alone
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bank_rd_req = 2'b11;
        @(negedge clk);
        // R1 reset state
        chk(reg_rd_data == 32'h0, "R1 rd_data", reg_rd_data, 32'h0);
        chk(bank_sleep == 2'b00, "R1 sleep", 32'(bank_sleep), 32'h0);
        chk(bank_rd_rdy == 2'b11, "R1 R4 rdy follows req", 32'(bank_rd_rdy), 32'h3);
        bank_rd_req = 2'b00;

        for (int i = 0; i < 6; i++) begin
            do_write(VEC[i][65:34]);
            chk(reg_rd_data == VEC[i][33:2], "R2 R9 R10 table rd", reg_rd_data, VEC[i][33:2]);
            chk(bank_sleep == VEC[i][1:0], "R2 R8 table sleep", 32'(bank_sleep), 32'(VEC[i][1:0]));
        end

        // bank1 finishes its wake, bank0 still asleep
        repeat (N + 2) @(negedge clk);
        bank_rd_req = 2'b10;
        #1;
        chk(bank_rd_rdy == 2'b10, "R3 R8 bank1 awake", 32'(bank_rd_rdy), 32'h2);
        bank_rd_req = 2'b00;

        // R5 auto wake of bank0 by request
        @(negedge clk);
        bank_rd_req = 2'b01;
        repeat (N) @(negedge clk);
        chk(bank_rd_rdy[0] == 1'b0, "R5 R4 rdy low at N-1", 32'(bank_rd_rdy[0]), 32'h0);
        chk(reg_rd_data == 32'h0, "R5 status cleared", reg_rd_data, 32'h0);
        @(negedge clk);
        chk(bank_rd_rdy[0] == 1'b1, "R5 rdy at N", 32'(bank_rd_rdy[0]), 32'h1);
        bank_rd_req = 2'b00;

        // R3 wake by command
        do_write(32'h40);
        chk(bank_sleep == 2'b01, "R2 bank0 asleep again", 32'(bank_sleep), 32'h1);
        do_write(32'h20);
        bank_rd_req = 2'b01;
        chk(bank_sleep == 2'b00, "R3 sleep low on wake", 32'(bank_sleep), 32'h0);
        repeat (N - 1) @(negedge clk);
        chk(bank_rd_rdy[0] == 1'b0, "R3 R4 rdy low at N-1", 32'(bank_rd_rdy[0]), 32'h0);
        @(negedge clk);
        chk(bank_rd_rdy[0] == 1'b1, "R3 rdy at N", 32'(bank_rd_rdy[0]), 32'h1);
        bank_rd_req = 2'b00;

        // R6 both bits on an awake bank
        bank_rd_req = 2'b10;
        do_write(32'h600);
        chk(bank_sleep == 2'b00, "R6 awake stays awake", 32'(bank_sleep), 32'h0);
        chk(bank_rd_rdy == 2'b10, "R6 R10 rdy kept", 32'(bank_rd_rdy), 32'h2);
        bank_rd_req = 2'b00;

        // R6 both bits on an asleep bank
        do_write(32'h400);
        do_write(32'h600);
        chk(reg_rd_data == 32'h0, "R6 asleep starts waking", reg_rd_data, 32'h0);

        // R7 sleep during wake is deferred
        repeat (10) @(negedge clk);
        do_write(32'h400);
        chk(bank_sleep == 2'b00, "R7 sleep held", 32'(bank_sleep), 32'h0);
        repeat (N) @(negedge clk);
        chk(bank_sleep == 2'b10, "R7 deferred sleep applied", 32'(bank_sleep), 32'h2);
        chk(reg_rd_data == 32'h100, "R7 status after deferred", reg_rd_data, 32'h100);
        chk(bank_rd_rdy == 2'b00, "R7 no ready", 32'(bank_rd_rdy), 32'h0);

        finish_run();
    end

endmodule